// File: doc/BRIEF.md
# Floating-Point Predicate Mask Comparator

This block compares two IEEE-754 operands under a predicate picked by a 6-bit function code. When the predicate holds it returns a mask of all ones across the operand width, and when it does not it returns all zeros. The format select chooses between binary32 and binary64. In binary32 mode only the low 32 bits of each operand are used, and the upper 32 bits of the result are zero. The mask can then feed a select or blend datapath directly, so no condition-code bit is involved.

The function code has four fields. A 3-bit base condition picks which of the relations {less, equal, unordered} count as true. One bit picks a signaling or a quiet comparison, and one bit moves to a second predicate group built on "greater as well as less". The top bit marks the code as out of range. Codes that are out of range, and codes that are unused in the second group, raise an illegal flag and produce a zero result. An invalid-operation condition is reported twice: as a per-operation cause bit, and as a sticky bit that collects every cause until reset.

Results, flags and an output strobe are registered one clock after the input valid strobe.

Top module: `fpcmp_mask`

## Requirements
- R1: The outputs `res_o`, `illegal_o` and `inv_cause_o` are registered on the clock edge at which `valid_i` is high, and `vld_o` is high for exactly that following cycle. While `valid_i` is low these outputs keep their values and `vld_o` is low.
- R2: The function code is split into four fields. `fc_i[2:0]` is the base condition. `fc_i[3]` selects signaling (1) or quiet (0). `fc_i[4]` selects the second predicate group (1) or the first (0). `fc_i[5]` marks the code as out of range.
- R3: When `fc_i[5]` is 1, `illegal_o` is set, `res_o` is zero and `inv_cause_o` is clear.
- R4: When `fc_i[4]` is 1 and `fc_i[2:0]` is 0, 4, 5, 6 or 7, `illegal_o` is set, `res_o` is zero and `inv_cause_o` is clear.
- R5: In the first group the predicate is true when the relation is one of those selected by the base condition: bit 2 selects less, bit 1 selects equal and bit 0 selects unordered. Code 0 is therefore never true, and a greater result never satisfies this group.
- R6: In the second group, code 1 is true for less, greater or equal (ordered). Code 2 is true for less, greater or unordered (not equal). Code 3 is true for less or greater.
- R7: A true result is 64 ones in binary64 mode. In binary32 mode it is `32'hFFFFFFFF` in the low half. Bits 63:32 are always zero in binary32 mode, and a false result is all zeros.
- R8: Relations are computed as follows. A NaN operand gives unordered. +0 and -0 are equal. Any negative value is less than any positive value. Two positive values order by exponent and then fraction. Two negative values order in the reverse of that magnitude order.
- R9: A legal signaling comparison raises the invalid cause when either operand is a NaN. A legal quiet comparison raises it only when an operand is a signaling NaN, that is, a NaN whose top fraction bit is 0.
- R10: `inv_sticky_o` becomes 1 with any invalid cause and stays 1 until reset.
- R11: While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| dbl_i | input | 1 | 1 = binary64, 0 = binary32 (low half) |
| fc_i | input | 6 | Function code |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| vld_o | output | 1 | Result strobe, one cycle after `valid_i` |
| res_o | output | 64 | Predicate mask |
| illegal_o | output | 1 | Function code is not allowed |
| inv_cause_o | output | 1 | Invalid operation raised by the last operation |
| inv_sticky_o | output | 1 | Accumulated invalid operation |

## Verification
The hardest cases to reach are where the relation and the NaN class interact with the predicate group. Examples are a quiet comparison that meets a signaling NaN in binary32, where the NaN bits sit in the low word and the upper word is filled with noise, and the second-group "not equal" code seen against unordered operands. To reach them, the stimulus sweeps all 64 function codes in both formats over every ordered pair from a table of twelve operands. The table holds signed zeros, ones, infinities, quiet and signaling NaNs, the smallest denormals and the largest finite values. The checking model builds a signed integer key for each operand, independently of the hardware comparator, and compares each registered output on every cycle, including idle cycles.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int MAG_W = 63;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             snan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } opnd_t;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic un;
  } rel_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EW = 11,
  parameter int FW = 52
) (
  input  logic [EW+FW:0] bits_i,
  output opnd_t          cls_o
);
  localparam int W = EW + FW + 1;

  logic [EW-1:0] expf;
  logic [FW-1:0] frac;
  logic          exp_max;

  assign expf    = bits_i[W-2:FW];
  assign frac    = bits_i[FW-1:0];
  assign exp_max = &expf;

  always_comb begin
    cls_o      = '0;
    cls_o.sign = bits_i[W-1];
    cls_o.nan  = exp_max && (frac != '0);
    cls_o.snan = exp_max && (frac != '0) && !frac[FW-1];
    cls_o.zero = (bits_i[W-2:0] == '0);
    cls_o.mag  = MAG_W'(bits_i[W-2:0]);
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
(
  input  opnd_t a_i,
  input  opnd_t b_i,
  output rel_t  rel_o
);
  logic unord;
  logic same;
  logic below;

  always_comb begin
    unord = a_i.nan || b_i.nan;
    same  = (a_i.zero && b_i.zero) ||
            ((a_i.sign == b_i.sign) && (a_i.mag == b_i.mag));
    below = (a_i.sign && !b_i.sign) ||
            (!a_i.sign && !b_i.sign && (a_i.mag < b_i.mag)) ||
            (a_i.sign && b_i.sign && (a_i.mag > b_i.mag));
    rel_o.un = unord;
    rel_o.eq = !unord && same;
    rel_o.lt = !unord && !same && below;
    rel_o.gt = !unord && !same && !below;
  end
endmodule

// File: rtl/fpcmp_decode.sv
module fpcmp_decode
  import fpcmp_pkg::*;
#(
  parameter int FC_W = 6
) (
  input  logic [FC_W-1:0] fc_i,
  output rel_t            cond_o,
  output logic            legal_o,
  output logic            sig_o
);
  logic [2:0] base;
  logic       neg_grp;

  assign base    = fc_i[2:0];
  assign neg_grp = fc_i[4];
  assign sig_o   = fc_i[3];

  always_comb begin
    cond_o = '0;
    if (!neg_grp) begin
      cond_o.lt = base[2];
      cond_o.eq = base[1];
      cond_o.un = base[0];
      legal_o   = !fc_i[5];
    end else begin
      cond_o.lt = 1'b1;
      cond_o.gt = 1'b1;
      cond_o.eq = base[0] && !base[1];
      cond_o.un = base[1] && !base[0];
      legal_o   = !fc_i[5] && !base[2] && (base[1:0] != 2'b00);
    end
  end
endmodule

// File: rtl/fpcmp_mask.sv
module fpcmp_mask
  import fpcmp_pkg::*;
#(
  parameter int DW   = 64,
  parameter int DEXP = 11,
  parameter int DFRC = 52,
  parameter int SEXP = 8,
  parameter int SFRC = 23,
  parameter int FC_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            valid_i,
  input  logic            dbl_i,
  input  logic [FC_W-1:0] fc_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic            vld_o,
  output logic [DW-1:0]   res_o,
  output logic            illegal_o,
  output logic            inv_cause_o,
  output logic            inv_sticky_o
);
  localparam int SW = 1 + SEXP + SFRC;
  localparam int NOP = 2;

  logic [DW-1:0] opnd  [NOP];
  opnd_t         cls_s [NOP];
  opnd_t         cls_d [NOP];
  opnd_t         cls   [NOP];

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar k = 0; k < NOP; k++) begin : g_op
    fpcmp_classify #(.EW(SEXP), .FW(SFRC)) u_sgl (
      .bits_i(opnd[k][SW-1:0]),
      .cls_o (cls_s[k])
    );
    fpcmp_classify #(.EW(DEXP), .FW(DFRC)) u_dbl (
      .bits_i(opnd[k][DW-1:0]),
      .cls_o (cls_d[k])
    );
    assign cls[k] = dbl_i ? cls_d[k] : cls_s[k];
  end

  rel_t rel;
  rel_t cond;
  logic legal;
  logic sig;

  fpcmp_order u_order (
    .a_i  (cls[0]),
    .b_i  (cls[1]),
    .rel_o(rel)
  );

  fpcmp_decode #(.FC_W(FC_W)) u_decode (
    .fc_i   (fc_i),
    .cond_o (cond),
    .legal_o(legal),
    .sig_o  (sig)
  );

  logic          hit;
  logic          inv_n;
  logic [DW-1:0] res_n;

  always_comb begin
    hit   = (cond.lt && rel.lt) || (cond.eq && rel.eq) ||
            (cond.gt && rel.gt) || (cond.un && rel.un);
    inv_n = legal && (sig ? (cls[0].nan || cls[1].nan)
                          : (cls[0].snan || cls[1].snan));
    res_n = '0;
    if (legal && hit) begin
      if (dbl_i) res_n = '1;
      else       res_n = {{(DW-SW){1'b0}}, {SW{1'b1}}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o        <= 1'b0;
      res_o        <= '0;
      illegal_o    <= 1'b0;
      inv_cause_o  <= 1'b0;
      inv_sticky_o <= 1'b0;
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        res_o       <= res_n;
        illegal_o   <= !legal;
        inv_cause_o <= inv_n;
        if (inv_n) inv_sticky_o <= 1'b1;
      end
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> vld_o);
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!vld_o && $stable(res_o) && $stable(illegal_o)));
  assert_out_of_range_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && fc_i[5]) |=> (illegal_o && res_o == '0 && !inv_cause_o));
  assert_reserved_neg_R4: assert property (@(posedge clk) disable iff (rst)
    (valid_i && fc_i[4] && (fc_i[2:0] == 3'd0 || fc_i[2:0] > 3'd3))
    |=> (illegal_o && res_o == '0));
  assert_single_upper_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !dbl_i) |=> (res_o[DW-1:SW] == '0));
  assert_double_uniform_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_i && dbl_i) |=> (res_o == '0 || res_o == '1));
  assert_sticky_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    inv_sticky_o |=> inv_sticky_o);
  assert_cause_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    inv_cause_o |-> inv_sticky_o);
endmodule

// File: tb/test_fpcmp_mask.sv
module test_fpcmp_mask;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic        dbl_i = 1'b0;
  logic [5:0]  fc_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        vld_o;
  logic [63:0] res_o;
  logic        illegal_o;
  logic        inv_cause_o;
  logic        inv_sticky_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit [63:0] e_res;
  bit        e_vld, e_ill, e_cause, e_stk;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcmp_mask i_fpcmp_mask (
    .clk(clk), .rst(rst), .valid_i(valid_i), .dbl_i(dbl_i), .fc_i(fc_i),
    .a_i(a_i), .b_i(b_i), .vld_o(vld_o), .res_o(res_o),
    .illegal_o(illegal_o), .inv_cause_o(inv_cause_o),
    .inv_sticky_o(inv_sticky_o)
  );

  bit [63:0] tbl_d [12];
  bit [31:0] tbl_s [12];

  function automatic void fields(input bit dbl, input bit [63:0] x,
                                 output bit nan, output bit sn,
                                 output longint key);
    int ew, fw, w;
    bit [63:0] v;
    bit s;
    longint unsigned mag, expf, frac;
    ew = dbl ? 11 : 8;
    fw = dbl ? 52 : 23;
    w  = dbl ? 64 : 32;
    v  = dbl ? x : {32'd0, x[31:0]};
    s  = v[w-1];
    mag  = v & ((64'd1 << (w-1)) - 64'd1);
    expf = mag >> fw;
    frac = mag & ((64'd1 << fw) - 64'd1);
    nan  = (expf == ((64'd1 << ew) - 64'd1)) && (frac != 0);
    sn   = nan && (((frac >> (fw-1)) & 64'd1) == 0);
    key  = s ? -longint'(mag) : longint'(mag);
  endfunction

  // Reference for R2..R9: relation from signed integer keys (R8), then a
  // per-code truth list written out case by case.
  function automatic void ref_op(input bit dbl, input bit [5:0] fc,
                                 input bit [63:0] a, input bit [63:0] b,
                                 output bit [63:0] res, output bit ill,
                                 output bit inv, output bit un);
    bit na, sa, nb, sb, lt, eq, gt, p;
    longint ka, kb;
    fields(dbl, a, na, sa, ka);
    fields(dbl, b, nb, sb, kb);
    un = na || nb;
    eq = !un && (ka == kb);
    lt = !un && (ka < kb);
    gt = !un && (ka > kb);
    ill = 1'b0;
    p = 1'b0;
    if (fc[5]) ill = 1'b1;
    else if (!fc[4]) begin
      case (fc[2:0])
        3'd0: p = 1'b0;
        3'd1: p = un;
        3'd2: p = eq;
        3'd3: p = un || eq;
        3'd4: p = lt;
        3'd5: p = un || lt;
        3'd6: p = lt || eq;
        default: p = un || lt || eq;
      endcase
    end else begin
      case (fc[2:0])
        3'd1: p = lt || gt || eq;
        3'd2: p = lt || gt || un;
        3'd3: p = lt || gt;
        default: ill = 1'b1;
      endcase
    end
    inv = !ill && (fc[3] ? (na || nb) : (sa || sb));
    if (ill || !p) res = 64'd0;
    else res = dbl ? {64{1'b1}} : 64'h0000_0000_FFFF_FFFF;
  endfunction

  task automatic chk(input bit ok, input string tag, input bit [63:0] act,
                     input bit [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (fc=%b dbl=%b a=%h b=%h)",
               tag, act, exp, fc_i, dbl_i, a_i, b_i);
    end
  endtask

  task automatic compare_all(input string rtag);
    chk(vld_o === e_vld, "R1 vld_o", 64'(vld_o), 64'(e_vld));
    chk(res_o === e_res, rtag, res_o, e_res);
    chk(illegal_o === e_ill, "R2 illegal_o", 64'(illegal_o), 64'(e_ill));
    chk(inv_cause_o === e_cause, "R9 inv_cause_o", 64'(inv_cause_o),
        64'(e_cause));
    chk(inv_sticky_o === e_stk, "R10 inv_sticky_o", 64'(inv_sticky_o),
        64'(e_stk));
  endtask

  // Called right after a negedge; drives, lets one posedge pass, compares.
  task automatic step(input bit v, input bit dbl, input bit [5:0] fc,
                      input bit [63:0] a, input bit [63:0] b);
    bit [63:0] r;
    bit il, iv, un;
    string tag;
    valid_i = v; dbl_i = dbl; fc_i = fc; a_i = a; b_i = b;
    e_vld = v;
    tag = "R1 res_o hold";
    if (v) begin
      ref_op(dbl, fc, a, b, r, il, iv, un);
      e_res = r; e_ill = il; e_cause = iv;
      if (iv) e_stk = 1'b1;
      if (il) tag = fc[5] ? "R3 res_o" : "R4 res_o";
      else if (!dbl) tag = "R7 res_o";
      else if (un) tag = "R9 res_o";
      else if (fc[4]) tag = "R6 res_o";
      else tag = "R5 R8 res_o";
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tbl_d = '{64'h0000000000000000, 64'h8000000000000000,
              64'h3FF0000000000000, 64'hBFF0000000000000,
              64'h4000000000000000, 64'h7FF0000000000000,
              64'hFFF0000000000000, 64'h7FF8000000000000,
              64'h7FF0000000000001, 64'h0000000000000001,
              64'h8000000000000001, 64'h7FEFFFFFFFFFFFFF};
    tbl_s = '{32'h00000000, 32'h80000000, 32'h3F800000, 32'hBF800000,
              32'h40000000, 32'h7F800000, 32'hFF800000, 32'h7FC00000,
              32'h7F800001, 32'h00000001, 32'h80000001, 32'h7F7FFFFF};
    e_res = '0; e_vld = 0; e_ill = 0; e_cause = 0; e_stk = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_all("R11 res_o reset");
    rst = 1'b0;
    for (int f = 0; f < 2; f++) begin
      for (int c = 0; c < 64; c++) begin
        for (int i = 0; i < 12; i++) begin
          for (int j = 0; j < 12; j++) begin
            if (f == 1)
              step(1'b1, 1'b1, 6'(c), tbl_d[i], tbl_d[j]);
            else
              step(1'b1, 1'b0, 6'(c), {32'hDEADBEEF, tbl_s[i]},
                   {32'hA5A5A5A5, tbl_s[j]});
          end
        end
        // idle cycle with changing inputs: outputs must hold (R1)
        step(1'b0, f[0], 6'(63 - c), tbl_d[c % 12], tbl_d[(c + 5) % 12]);
      end
    end
    // reset clears sticky and every output (R11, R10)
    valid_i = 1'b0;
    rst = 1'b1;
    e_res = '0; e_vld = 0; e_ill = 0; e_cause = 0; e_stk = 0;
    @(posedge clk);
    @(negedge clk);
    compare_all("R11 res_o second reset");
    rst = 1'b0;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule